// File: doc/BRIEF.md
# Windowed Banked Work-RAM Mapper

This block decodes host bus addresses for a shared on-chip work RAM that is split into three sets. Set A has four parts of 64 KB and sets B and C have eight parts of 32 KB each. Each set appears on the bus through a programmable window inside the RAM region, where the upper address byte is 0x03. Each part has a bank register. The bank register enables the part and places it at a slot inside its set's repeating image.

On every valid access the block works out whether banked RAM answers. If so, it picks the winning set by a fixed priority and drives one enable per RAM part. A read enables only the lowest-numbered matching part. A write enables every matching part, so overlapping parts are all written at once. Accesses that no window claims raise a miss, so the next decoder, for example the I/O register decoder, can take them. Window and bank registers are loaded through a synchronous port with byte enables and read back one cycle later.

Top module: `wram_mapper`

## Requirements
- R1: After reset, every window and bank register reads 0, and no access hits, because start 0 and end 0 make an empty window.
- R2: A set's window holds a start index and an end index. The unit is 64 KB for set A and 32 KB for sets B and C. For set A the start is bits [11:4] and the end is bits [28:20]. For sets B and C the start is bits [11:3] and the end is bits [28:19]. An address 0x03000000 + i*unit lies inside the window when start <= i < end. An end above 0x100 (set A) or 0x200 (sets B and C) acts as that limit. An end at or below the start gives an empty window.
- R3: When windows overlap, set A wins over B and B wins over C, for reads and for writes alike. The winner sets acc_hit and its own bit in acc_set (bit 0 A, bit 1 B, bit 2 C). Only the winner's parts may be enabled, even when none of its parts match.
- R4: On a read, only the lowest-numbered matching part of the winning set is enabled.
- R5: On a write, every matching part of the winning set is enabled.
- R6: A part matches when its bank bit 7 is 1 and its slot field equals (i - start) modulo the image size. The slot field is bits [3:2] for set A and bits [4:2] for sets B and C. The image size is min(parts in the set, 2^s) parts, where s is window bits [13:12].
- R7: An address whose upper byte is not 0x03, including the I/O region 0x04, never hits. It raises acc_miss, even when a window end reaches past the RAM region.
- R8: Bits 0xE00FC00F of the set A window and bits 0xE007C007 of the set B and C windows always read 0. Every other window bit reads back as written, including end values above the limit.
- R9: Bank bits 0x72 for set A and 0x60 for sets B and C can never be set.
- R10: With map_en low, no access hits. Registers remain writable and readable with the same masks.
- R11: The results of an access appear on the outputs one cycle after it is presented. With bus_valid low, the outputs are all zero on the next cycle.
- R12: Only bytes whose reg_be bit is set are written in a window register. A bank register is written only when reg_be[0] is set, from reg_wdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Global enable for the RAM mapping |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 17 | Byte address bits [31:15] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index: 0..2 windows A/B/C, 8+p bank A, 16+p bank B, 24+p bank C |
| reg_be | input | 4 | Byte enables for register writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr, one cycle later |
| acc_hit | output | 1 | Access served by banked RAM |
| acc_miss | output | 1 | Valid access not served by banked RAM |
| acc_set | output | 3 | One-hot winning set (bit 0 A, 1 B, 2 C) |
| part_en | output | 20 | Part enables: [3:0] set A, [11:4] set B, [19:12] set C |

## Verification
The assertions assume that bus_valid, bus_write, map_en and the address are driven to known values in every cycle after reset, and that register writes never collide with a check of the same register's readback. The bench drives every input from the falling edge, keeps the bus idle during reset, and gives each access exactly one cycle. For each access it computes the expected hit, set and part enables from its own copy of the masked register values. It sweeps overlapping windows, windows clamped at the limit, empty windows, the I/O region and the disabled state.

// File: rtl/wram_pkg.sv
package wram_pkg;
  localparam logic [7:0] RAM_REGION = 8'h03;
  localparam logic [7:0] IO_REGION  = 8'h04;

  // register index groups
  localparam logic [1:0] GRP_WIN = 2'd0;
  localparam logic [1:0] GRP_A   = 2'd1;
  localparam logic [1:0] GRP_B   = 2'd2;
  localparam logic [1:0] GRP_C   = 2'd3;

  function automatic logic [31:0] field_mask(input int lo, input int w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i < lo + w) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wram_set.sv
module wram_set
  import wram_pkg::*;
#(
  parameter int         PART_LOG   = 16,
  parameter int         NPARTS     = 4,
  parameter logic [7:0] BANK_WMASK = 8'h8D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   win_we,
  input  logic [NPARTS-1:0]      bank_we,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic [31:PART_LOG]     addr_hi,
  output logic [31:0]            win_q,
  output logic [NPARTS-1:0][7:0] bank_q,
  output logic                   win_hit,
  output logic [NPARTS-1:0]      rd_sel,
  output logic [NPARTS-1:0]      wr_sel
);
  localparam int IW       = 24 - PART_LOG;
  localparam int SW       = $clog2(NPARTS);
  localparam int START_LO = 12 - IW;
  localparam int END_LO   = 28 - IW;
  localparam logic [31:0] WIN_WMASK =
    field_mask(START_LO, IW) | field_mask(12, 2) | field_mask(END_LO, IW + 1);

  logic [31:0]   bmask;
  logic [IW-1:0] idx, w_start;
  logic [IW:0]   w_end;
  logic          in_ram;
  logic [SW-1:0] mmask, slot;

  assign bmask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (win_we) begin
      win_q <= (win_q & ~(bmask & WIN_WMASK)) | (wdata & bmask & WIN_WMASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else begin
      for (int p = 0; p < NPARTS; p++) begin
        if (bank_we[p] && be[0]) bank_q[p] <= wdata[7:0] & BANK_WMASK;
      end
    end
  end

  assign idx     = addr_hi[23:PART_LOG];
  assign in_ram  = (addr_hi[31:24] == RAM_REGION);
  assign w_start = win_q[START_LO +: IW];
  assign w_end   = win_q[END_LO +: IW + 1];

  always_comb begin
    win_hit = in_ram && (idx >= w_start) && ({1'b0, idx} < w_end);
    for (int b = 0; b < SW; b++) mmask[b] = (int'(win_q[13:12]) > b);
    slot = (idx[SW-1:0] - w_start[SW-1:0]) & mmask;
  end

  genvar gp;
  generate
    for (gp = 0; gp < NPARTS; gp++) begin : g_match
      assign wr_sel[gp] = win_hit && bank_q[gp][7] && (bank_q[gp][2 +: SW] == slot);
    end
  endgenerate

  always_comb begin
    logic found;
    found  = 1'b0;
    rd_sel = '0;
    for (int p = 0; p < NPARTS; p++) begin
      if (wr_sel[p] && !found) begin
        rd_sel[p] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  // R4
  rd_any_chk: assert property (@(posedge clk) disable iff (rst)
    ((|wr_sel) == (|rd_sel)));
endmodule

// File: rtl/wram_prio.sv
module wram_prio #(
  parameter int NA = 4,
  parameter int NB = 8,
  parameter int NC = 8
) (
  input  logic [2:0]          hit,
  input  logic                wr,
  input  logic [NA-1:0]       rd_a,
  input  logic [NA-1:0]       wr_a,
  input  logic [NB-1:0]       rd_b,
  input  logic [NB-1:0]       wr_b,
  input  logic [NC-1:0]       rd_c,
  input  logic [NC-1:0]       wr_c,
  output logic [2:0]          set_oh,
  output logic [NA+NB+NC-1:0] parts
);
  always_comb begin
    parts = '0;
    if (hit[0]) begin
      set_oh         = 3'b001;
      parts[0 +: NA] = wr ? wr_a : rd_a;
    end else if (hit[1]) begin
      set_oh          = 3'b010;
      parts[NA +: NB] = wr ? wr_b : rd_b;
    end else if (hit[2]) begin
      set_oh               = 3'b100;
      parts[NA+NB +: NC]   = wr ? wr_c : rd_c;
    end else begin
      set_oh = 3'b000;
    end
  end
endmodule

// File: rtl/wram_mapper.sv
module wram_mapper
  import wram_pkg::*;
#(
  parameter int         A_PARTS      = 4,
  parameter int         BC_PARTS     = 8,
  parameter int         A_PART_LOG   = 16,
  parameter int         BC_PART_LOG  = 15,
  parameter logic [7:0] BANK_WMASK_A  = 8'h8D,
  parameter logic [7:0] BANK_WMASK_BC = 8'h9F,
  localparam int        ADDR_LO = (A_PART_LOG < BC_PART_LOG) ? A_PART_LOG : BC_PART_LOG,
  localparam int        NP      = A_PARTS + 2 * BC_PARTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [31:ADDR_LO] bus_addr,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              acc_hit,
  output logic              acc_miss,
  output logic [2:0]        acc_set,
  output logic [NP-1:0]     part_en
);
  logic [A_PARTS-1:0]       bwe_a, rd_a, wr_a;
  logic [BC_PARTS-1:0]      bwe_b, rd_b, wr_b, bwe_c, rd_c, wr_c;
  logic [31:0]              win_a, win_b, win_c, rd_mux;
  logic [A_PARTS-1:0][7:0]  bank_a;
  logic [BC_PARTS-1:0][7:0] bank_b, bank_c;
  logic [2:0]               win_hit, hit_g, set_oh;
  logic [NP-1:0]            parts;
  logic                     acc_wr_q;

  // register write decode
  always_comb begin
    for (int p = 0; p < A_PARTS; p++)
      bwe_a[p] = reg_we && (reg_addr == {GRP_A, 3'(p)});
    for (int p = 0; p < BC_PARTS; p++) begin
      bwe_b[p] = reg_we && (reg_addr == {GRP_B, 3'(p)});
      bwe_c[p] = reg_we && (reg_addr == {GRP_C, 3'(p)});
    end
  end

  wram_set #(.PART_LOG(A_PART_LOG), .NPARTS(A_PARTS), .BANK_WMASK(BANK_WMASK_A)) u_set_a (
    .clk(clk), .rst(rst),
    .win_we(reg_we && reg_addr == 5'd0), .bank_we(bwe_a), .be(reg_be), .wdata(reg_wdata),
    .addr_hi(bus_addr[31:A_PART_LOG]),
    .win_q(win_a), .bank_q(bank_a), .win_hit(win_hit[0]), .rd_sel(rd_a), .wr_sel(wr_a)
  );

  wram_set #(.PART_LOG(BC_PART_LOG), .NPARTS(BC_PARTS), .BANK_WMASK(BANK_WMASK_BC)) u_set_b (
    .clk(clk), .rst(rst),
    .win_we(reg_we && reg_addr == 5'd1), .bank_we(bwe_b), .be(reg_be), .wdata(reg_wdata),
    .addr_hi(bus_addr[31:BC_PART_LOG]),
    .win_q(win_b), .bank_q(bank_b), .win_hit(win_hit[1]), .rd_sel(rd_b), .wr_sel(wr_b)
  );

  wram_set #(.PART_LOG(BC_PART_LOG), .NPARTS(BC_PARTS), .BANK_WMASK(BANK_WMASK_BC)) u_set_c (
    .clk(clk), .rst(rst),
    .win_we(reg_we && reg_addr == 5'd2), .bank_we(bwe_c), .be(reg_be), .wdata(reg_wdata),
    .addr_hi(bus_addr[31:BC_PART_LOG]),
    .win_q(win_c), .bank_q(bank_c), .win_hit(win_hit[2]), .rd_sel(rd_c), .wr_sel(wr_c)
  );

  assign hit_g = win_hit & {3{bus_valid & map_en}};

  wram_prio #(.NA(A_PARTS), .NB(BC_PARTS), .NC(BC_PARTS)) u_prio (
    .hit(hit_g), .wr(bus_write),
    .rd_a(rd_a), .wr_a(wr_a), .rd_b(rd_b), .wr_b(wr_b), .rd_c(rd_c), .wr_c(wr_c),
    .set_oh(set_oh), .parts(parts)
  );

  // register readback mux
  always_comb begin
    rd_mux = '0;
    case (reg_addr[4:3])
      GRP_WIN: begin
        if (reg_addr[2:0] == 3'd0) rd_mux = win_a;
        if (reg_addr[2:0] == 3'd1) rd_mux = win_b;
        if (reg_addr[2:0] == 3'd2) rd_mux = win_c;
      end
      GRP_A: for (int p = 0; p < A_PARTS; p++)
               if (reg_addr[2:0] == 3'(p)) rd_mux = {24'b0, bank_a[p]};
      GRP_B: for (int p = 0; p < BC_PARTS; p++)
               if (reg_addr[2:0] == 3'(p)) rd_mux = {24'b0, bank_b[p]};
      default: for (int p = 0; p < BC_PARTS; p++)
               if (reg_addr[2:0] == 3'(p)) rd_mux = {24'b0, bank_c[p]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      acc_hit   <= 1'b0;
      acc_miss  <= 1'b0;
      acc_set   <= '0;
      part_en   <= '0;
      acc_wr_q  <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      acc_hit   <= |set_oh;
      acc_miss  <= bus_valid && !(|set_oh);
      acc_set   <= set_oh;
      part_en   <= parts;
      acc_wr_q  <= bus_valid && bus_write;
    end
  end

  // R3
  set_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(acc_set));
  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_wr_q |-> $onehot0(part_en));
  // R7
  io_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[31:24] == IO_REGION) |=> (acc_miss && !acc_hit));
  // R10
  off_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !map_en) |=> (!acc_hit && part_en == '0));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!acc_hit && !acc_miss && part_en == '0));
  // R11
  hit_miss_chk: assert property (@(posedge clk) disable iff (rst) !(acc_hit && acc_miss));
endmodule

// File: tb/test_wram_mapper.sv
module test_wram_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_en = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:15] bus_addr = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_hit, acc_miss;
  logic [2:0]  acc_set;
  logic [19:0] part_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wram_mapper i_wram_mapper (
    .clk(clk), .rst(rst), .map_en(map_en), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_hit(acc_hit), .acc_miss(acc_miss),
    .acc_set(acc_set), .part_en(part_en)
  );

  typedef struct {
    logic        hit;
    logic        miss;
    logic [2:0]  set;
    logic [19:0] parts;
    string       tag;
  } item_t;

  item_t q[$];

  // bench-side register image
  logic [31:0] m_win[3];
  logic [7:0]  m_bank[3][8];

  function automatic item_t model(input logic [31:0] a, input bit w, input string tag);
    item_t it;
    bit found = 0;
    it.hit = 0; it.miss = 0; it.set = '0; it.parts = '0; it.tag = tag;
    for (int s = 0; s < 3; s++) begin
      int plog = (s == 0) ? 16 : 15;
      int iw   = 24 - plog;
      int np   = (s == 0) ? 4 : 8;
      int base = (s == 0) ? 0 : ((s == 1) ? 4 : 12);
      int idx  = int'(a[23:0] >> plog);
      int st   = int'(m_win[s] >> (12 - iw)) & ((1 << iw) - 1);
      int en   = int'(m_win[s] >> (28 - iw)) & ((1 << (iw + 1)) - 1);
      if (en > (1 << iw)) en = 1 << iw;
      if (!found && map_en && a[31:24] == 8'h03 && idx >= st && idx < en) begin
        int sz  = int'(m_win[s] >> 12) & 3;
        int msz = 1 << sz;
        int slot;
        bit first = 1;
        found = 1;
        it.set[s] = 1'b1;
        if (msz > np) msz = np;
        slot = (idx - st) % msz;
        for (int p = 0; p < np; p++) begin
          int sf = (s == 0) ? ((int'(m_bank[s][p]) >> 2) & 3) : ((int'(m_bank[s][p]) >> 2) & 7);
          if (m_bank[s][p][7] && sf == slot) begin
            if (w || first) it.parts[base + p] = 1'b1;
            first = 0;
          end
        end
      end
    end
    it.hit  = found;
    it.miss = !found;
    return it;
  endfunction

  task automatic wr_reg(input int a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] bm, wm;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 1'b0;
    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    if (a < 3) begin
      wm = (a == 0) ? 32'h1FF03FF0 : 32'h1FF83FF8;
      m_win[a] = (m_win[a] & ~(bm & wm)) | (d & bm & wm);
    end else if (be[0]) begin
      int s = (a >> 3) - 1;
      m_bank[s][a & 7] = d[7:0] & ((s == 0) ? 8'h8D : 8'h9F);
    end
  endtask

  task automatic chk_reg(input int a, input logic [31:0] exp, input string r);
    @(negedge clk);
    reg_addr = 5'(a);
    @(posedge clk); #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s reg %0d actual=%08h expected=%08h", r, a, reg_rdata, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input string r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a[31:15];
    q.push_back(model(a, w, r));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare registered results against the queued expectations
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (acc_hit !== e.hit || acc_miss !== e.miss || acc_set !== e.set || part_en !== e.parts) begin
          errors++;
          $display("FAIL %s actual hit=%b miss=%b set=%b parts=%05h expected hit=%b miss=%b set=%b parts=%05h",
                   e.tag, acc_hit, acc_miss, acc_set, part_en, e.hit, e.miss, e.set, e.parts);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) begin
      m_win[s] = '0;
      for (int p = 0; p < 8; p++) m_bank[s][p] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_reg(0, 32'h0, "R1");
    chk_reg(2, 32'h0, "R1");
    chk_reg(16, 32'h0, "R1");
    acc(32'h0300_0000, 1'b0, "R1");
    idle(1);

    // R8 / R9 masks
    wr_reg(0, 32'hFFFF_FFFF, 4'hF);
    chk_reg(0, 32'h1FF0_3FF0, "R8");
    wr_reg(1, 32'hFFFF_FFFF, 4'hF);
    chk_reg(1, 32'h1FF8_3FF8, "R8");
    wr_reg(8, 32'hFF, 4'h1);
    chk_reg(8, 32'h8D, "R9");
    wr_reg(16, 32'hFF, 4'h1);
    chk_reg(16, 32'h9F, "R9");
    // R12 byte enables
    wr_reg(0, 32'h0, 4'b0001);
    chk_reg(0, 32'h1FF0_3F00, "R12");
    wr_reg(8, 32'h00, 4'b0000);
    chk_reg(8, 32'h8D, "R12");

    // configuration
    wr_reg(0, 32'h0140_2100, 4'hF);  // A: 0x10..0x14 (64K), image 4 parts
    wr_reg(1, 32'h0180_3100, 4'hF);  // B: 0x20..0x30 (32K), image 8 parts
    wr_reg(2, 32'h1FF8_0FC0, 4'hF);  // C: 0x1F8..0x3FF clamped, image 1 part
    chk_reg(2, 32'h1FF8_0FC0, "R8");
    wr_reg(8, 32'h80, 4'h1);
    wr_reg(9, 32'h84, 4'h1);
    wr_reg(10, 32'h84, 4'h1);
    wr_reg(11, 32'h08, 4'h1);
    wr_reg(16, 32'h80, 4'h1);
    wr_reg(27, 32'h80, 4'h1);
    wr_reg(29, 32'h80, 4'h1);

    acc(32'h0310_0000, 1'b0, "R3");   // A beats B
    acc(32'h0310_0000, 1'b1, "R3");
    acc(32'h0311_0000, 1'b0, "R4");   // p1 only
    acc(32'h0311_0000, 1'b1, "R5");   // p1 and p2
    acc(32'h0312_0000, 1'b0, "R6");   // slot 2 disabled part
    acc(32'h0314_0000, 1'b0, "R6");   // B, wrap to slot 0
    acc(32'h0313_8000, 1'b1, "R3");
    acc(32'h030F_0000, 1'b0, "R2");   // below all windows
    acc(32'h0318_0000, 1'b0, "R2");   // B end
    acc(32'h03FC_0000, 1'b0, "R2");   // C start
    acc(32'h03FF_8000, 1'b1, "R5");   // C clamp, two parts
    acc(32'h03FF_8000, 1'b0, "R4");
    acc(32'h0400_0000, 1'b0, "R7");
    acc(32'h0400_4040, 1'b1, "R7");
    acc(32'h0210_0000, 1'b0, "R7");
    idle(1);
    // R11 idle outputs
    @(posedge clk); #1;
    checks++;
    if (acc_hit !== 1'b0 || acc_miss !== 1'b0 || part_en !== '0) begin
      errors++;
      $display("FAIL R11 actual hit=%b miss=%b parts=%05h expected 0 0 00000", acc_hit, acc_miss, part_en);
    end

    // R2 empty window lets B through; then clamp window for A
    wr_reg(0, 32'h0100_2100, 4'hF);
    acc(32'h0310_0000, 1'b0, "R2");
    wr_reg(0, 32'h1FF0_0FF0, 4'hF);
    chk_reg(0, 32'h1FF0_0FF0, "R8");
    acc(32'h03FF_0000, 1'b1, "R3");
    acc(32'h0400_0000, 1'b1, "R7");

    // R10 disabled mapping
    @(negedge clk);
    map_en = 1'b0;
    acc(32'h03FF_0000, 1'b0, "R10");
    acc(32'h0314_0000, 1'b1, "R10");
    wr_reg(17, 32'hFF, 4'h1);
    chk_reg(17, 32'h9F, "R10");
    @(negedge clk);
    map_en = 1'b1;
    acc(32'h03FF_0000, 1'b0, "R10");
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule